// File: doc/BRIEF.md
# Segment Access Checker

This block sits behind the segment descriptor cache of an address-generation stage. For each memory access it gets the cached descriptor fields and the effective offset. It adds the segment base to the offset to form the linear address. In parallel it decides whether the access is allowed: present bit, descriptor class, type-based permission for the access kind, and the segment bounds. The bounds use byte or 4 KB granularity, and the valid range is inverted for data segments that grow downwards.

The decision is made combinationally from the inputs. Address, fault flag and cause code are captured in one output register stage, so results appear one clock after the inputs. A new access may be presented on every cycle. Privilege comparison, descriptor fetching and paging are handled elsewhere.

Top module: `seg_access_check`

## Requirements
- R1: `lin_addr` equals `desc_base + acc_offset` modulo 2^32, for the inputs present at the previous rising clock edge. This holds whether or not the access faults.
- R2: When `desc_present` is 0, `fault_cause` is 1 (not present), whatever the other inputs are.
- R3: Cause codes are 0 = none, 1 = not present, 2 = limit, 3 = rights. `fault` is 1 exactly when `fault_cause` is non-zero. While `rst_n` is low, `lin_addr`, `fault` and `fault_cause` are all 0.
- R4: The effective limit is `desc_limit` zero-extended when `desc_gran` is 0. When `desc_gran` is 1, it is `desc_limit` shifted left by 12 with the low 12 bits set to one.
- R5: For code segments, and for data segments with `desc_type[2]`=0, the access is within bounds only if `acc_offset + acc_bytes - 1`, computed without wrap, is at most the effective limit.
- R6: For data segments with `desc_type[2]`=1 (grows down), the access is within bounds only if `acc_offset` is above the effective limit and the last byte is at most 0xFFFF (`desc_big`=0) or 0xFFFFFFFF (`desc_big`=1).
- R7: `desc_type[3]`=1 marks a code segment. A write to it is a rights fault. A read needs `desc_type[1]`=1. A fetch is always allowed. `desc_type[2]` has no effect on code segments.
- R8: `desc_type[3]`=0 marks a data segment. A fetch from it is a rights fault. A write needs `desc_type[1]`=1. A read is always allowed.
- R9: `desc_type[0]` (the accessed flag) has no effect on any output.
- R10: A descriptor with `desc_user`=0 (system class), or `acc_kind`=3 (unused code), gives a rights fault when the segment is present.
- R11: Precedence is not present, then rights, then limit. An access breaking both the rights rule and the bounds reports cause 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 20 | Raw segment limit field |
| desc_gran | input | 1 | Limit unit: 0 byte, 1 4 KB page |
| desc_big | input | 1 | Upper bound for grow-down segments: 0 16-bit, 1 32-bit |
| desc_present | input | 1 | Segment present |
| desc_user | input | 1 | 1 code/data descriptor, 0 system descriptor |
| desc_type | input | 4 | [3] code, [2] grow-down/conforming, [1] write/read enable, [0] accessed |
| acc_offset | input | 32 | Effective offset of the access |
| acc_bytes | input | 4 | Access size in bytes, 1 to 15 |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 unused |
| lin_addr | output | 32 | Registered linear address |
| fault | output | 1 | Registered fault flag |
| fault_cause | output | 2 | Registered cause code |

## Verification
The hardest cases are accesses whose last byte lands exactly on a bound. Examples are an expand-up access ending on the scaled limit, or a grow-down access that starts one byte above the limit or ends on 0xFFFF or 0xFFFFFFFF. Offsets taken at random almost never hit these. The stimulus therefore derives its offsets from each chosen limit: it places them just below, on and just above the effective limit and both upper bounds. It does this for several access sizes, both granularities, both bound widths and all sixteen type codes, so that every bound is crossed by exactly one byte in each direction.

// File: rtl/seg_chk_pkg.sv
// Shared encodings for the segment access checker.
// Assumes a 2-bit access kind and a 2-bit fault cause.
package seg_chk_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_LIMIT  = 2'd2,
        CAUSE_RIGHTS = 2'd3
    } fault_cause_t;
endpackage

// File: rtl/seg_eff_limit.sv
// Scales the raw limit field into a byte limit.
// Assumes LIMIT_W + GRAN_SHIFT <= ADDR_W.
module seg_eff_limit #(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int GRAN_SHIFT = 12
) (
    input  logic [LIMIT_W-1:0] raw_limit,
    input  logic               gran,
    output logic [ADDR_W-1:0]  eff_limit
);
    localparam logic [ADDR_W-1:0] FILL = (ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1);

    // Pick byte limit or page limit with the low bits filled with ones.
    always_comb begin
        if (gran)
            eff_limit = (ADDR_W'(raw_limit) << GRAN_SHIFT) | FILL;
        else
            eff_limit = ADDR_W'(raw_limit);
    end
endmodule

// File: rtl/seg_bound_check.sv
// Decides whether every byte of an access lies inside the segment.
// Assumes size >= 1. The last byte is computed one bit wider, so no wrap is possible.
module seg_bound_check #(
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 4,
    parameter int SMALL_W = 16
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] eff_limit,
    input  logic              grows_down,
    input  logic              big,
    output logic              in_bounds
);
    localparam int EXT_W = ADDR_W + 1;
    localparam logic [EXT_W-1:0] SMALL_TOP = (EXT_W'(1) << SMALL_W) - EXT_W'(1);
    localparam logic [EXT_W-1:0] BIG_TOP   = (EXT_W'(1) << ADDR_W) - EXT_W'(1);

    logic [EXT_W-1:0] last_byte;
    logic [EXT_W-1:0] top;

    // Address of the final byte touched, without wrap.
    always_comb last_byte = EXT_W'(offset) + EXT_W'(size) - EXT_W'(1);

    // Upper bound of a grow-down segment.
    always_comb top = big ? BIG_TOP : SMALL_TOP;

    // Range test: inverted lower bound for grow-down, plain limit otherwise.
    always_comb begin
        if (grows_down)
            in_bounds = (offset > eff_limit) && (last_byte <= top);
        else
            in_bounds = (last_byte <= EXT_W'(eff_limit));
    end
endmodule

// File: rtl/seg_type_rights.sv
// Decodes the descriptor class and type into a permission verdict
// and the grow-down flag. The accessed bit is not an input.
module seg_type_rights
    import seg_chk_pkg::*;
(
    input  logic      user_desc,
    input  logic      is_code,
    input  logic      dir_conf,
    input  logic      rw_enable,
    input  acc_kind_t kind,
    output logic      rights_ok,
    output logic      grows_down
);
    // Only data segments can grow down; for code, bit 2 means conforming.
    always_comb grows_down = !is_code && dir_conf;

    // Permission table by segment class and access kind.
    always_comb begin
        rights_ok = 1'b0;
        if (user_desc) begin
            unique case (kind)
                KIND_READ:  rights_ok = is_code ? rw_enable : 1'b1;
                KIND_WRITE: rights_ok = is_code ? 1'b0 : rw_enable;
                KIND_FETCH: rights_ok = is_code;
                default:    rights_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/seg_access_check.sv
// Segment access checker top: linear address adder, rights and bounds
// verdicts, fixed-precedence cause, one registered output stage.
// Assumes acc_bytes is non-zero.
module seg_access_check
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int GRAN_SHIFT = 12,
    parameter int SIZE_W     = 4,
    parameter int SMALL_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  desc_base,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic               desc_gran,
    input  logic               desc_big,
    input  logic               desc_present,
    input  logic               desc_user,
    input  logic [3:0]         desc_type,
    input  logic [ADDR_W-1:0]  acc_offset,
    input  logic [SIZE_W-1:0]  acc_bytes,
    input  logic [1:0]         acc_kind,
    output logic [ADDR_W-1:0]  lin_addr,
    output logic               fault,
    output logic [1:0]         fault_cause
);
    logic [ADDR_W-1:0] eff_limit;
    logic              rights_ok;
    logic              grows_down;
    logic              in_bounds;
    fault_cause_t      cause_n;
    logic              unused_accessed;

    // The accessed flag is carried by the descriptor but plays no part here.
    assign unused_accessed = desc_type[0];

    seg_eff_limit #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .GRAN_SHIFT(GRAN_SHIFT)) u_lim (
        .raw_limit (desc_limit),
        .gran      (desc_gran),
        .eff_limit (eff_limit)
    );

    seg_type_rights u_rights (
        .user_desc  (desc_user),
        .is_code    (desc_type[3]),
        .dir_conf   (desc_type[2]),
        .rw_enable  (desc_type[1]),
        .kind       (acc_kind_t'(acc_kind)),
        .rights_ok  (rights_ok),
        .grows_down (grows_down)
    );

    seg_bound_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SMALL_W(SMALL_W)) u_bound (
        .offset     (acc_offset),
        .size       (acc_bytes),
        .eff_limit  (eff_limit),
        .grows_down (grows_down),
        .big        (desc_big),
        .in_bounds  (in_bounds)
    );

    // Fixed precedence: absent, then rights, then bounds.
    always_comb begin
        if (!desc_present)  cause_n = CAUSE_ABSENT;
        else if (!rights_ok) cause_n = CAUSE_RIGHTS;
        else if (!in_bounds) cause_n = CAUSE_LIMIT;
        else                 cause_n = CAUSE_NONE;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_addr    <= '0;
            fault       <= 1'b0;
            fault_cause <= CAUSE_NONE;
        end else begin
            lin_addr    <= desc_base + acc_offset;
            fault       <= (cause_n != CAUSE_NONE);
            fault_cause <= cause_n;
        end
    end
endmodule

// File: rtl/seg_access_check_sva.sv
// Property checker for seg_access_check, attached by bind.
// Relates the inputs of one cycle to the registered outputs of the next.
module seg_access_check_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] desc_base,
    input logic [ADDR_W-1:0] acc_offset,
    input logic              desc_present,
    input logic              desc_user,
    input logic [3:0]        desc_type,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] lin_addr,
    input logic [1:0]        fault_cause
);
    logic              primed;
    logic [ADDR_W-1:0] sum_in;

    // Marks that one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // Sum of the current inputs, for comparison one cycle later.
    always_comb sum_in = desc_base + acc_offset;

    assert_lin_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> lin_addr == $past(sum_in));

    assert_absent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(!desc_present)) |-> fault_cause == 2'd1);

    assert_code_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(desc_present && desc_user && desc_type[3] && acc_kind == 2'd1))
        |-> fault_cause == 2'd3);

    assert_data_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(desc_present && desc_user && !desc_type[3] && acc_kind == 2'd2))
        |-> fault_cause == 2'd3);

    assert_system_desc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(desc_present && !desc_user)) |-> fault_cause == 2'd3);
endmodule

bind seg_access_check seg_access_check_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_base    (desc_base),
    .acc_offset   (acc_offset),
    .desc_present (desc_present),
    .desc_user    (desc_user),
    .desc_type    (desc_type),
    .acc_kind     (acc_kind),
    .lin_addr     (lin_addr),
    .fault_cause  (fault_cause)
);

// File: tb/seg_access_check_test.sv
module seg_access_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic        desc_big = 1'b0;
    logic        desc_present = 1'b0;
    logic        desc_user = 1'b0;
    logic [3:0]  desc_type = '0;
    logic [31:0] acc_offset = '0;
    logic [3:0]  acc_bytes = 4'd1;
    logic [1:0]  acc_kind = '0;
    logic [31:0] lin_addr;
    logic        fault;
    logic [1:0]  fault_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int vec = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_access_check uut (
        .clk(clk), .rst_n(rst_n), .desc_base(desc_base), .desc_limit(desc_limit),
        .desc_gran(desc_gran), .desc_big(desc_big), .desc_present(desc_present),
        .desc_user(desc_user), .desc_type(desc_type), .acc_offset(acc_offset),
        .acc_bytes(acc_bytes), .acc_kind(acc_kind), .lin_addr(lin_addr),
        .fault(fault), .fault_cause(fault_cause)
    );

    // Expected cause from the requirements.
    function automatic logic [1:0] model_cause(
        input logic p, input logic u, input logic [3:0] t, input logic [1:0] k,
        input logic [19:0] lim, input logic g, input logic big,
        input logic [31:0] off, input logic [3:0] sz);
        logic [32:0] eff;
        logic [32:0] last;
        logic        ok;
        if (!p) return 2'd1;
        if (!u || k == 2'd3) return 2'd3;
        if (t[3]) begin
            if (k == 2'd1) return 2'd3;
            if (k == 2'd0 && !t[1]) return 2'd3;
        end else begin
            if (k == 2'd2) return 2'd3;
            if (k == 2'd1 && !t[1]) return 2'd3;
        end
        eff  = g ? ({13'd0, lim} * 33'd4096 + 33'd4095) : {13'd0, lim};
        last = {1'b0, off} + {29'd0, sz} - 33'd1;
        if (!t[3] && t[2])
            ok = ({1'b0, off} > eff) && (last <= (big ? 33'hFFFFFFFF : 33'h0000FFFF));
        else
            ok = (last <= eff);
        return ok ? 2'd0 : 2'd3 - 2'd1;
    endfunction

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (vector %0d)", tag, act, exp, vec);
        end
    endtask

    // Drive one access at a falling edge and check the registered result one cycle later.
    task automatic run_vec(input logic p, input logic u, input logic [3:0] t, input logic [1:0] k,
                           input logic [19:0] lim, input logic g, input logic big,
                           input logic [31:0] off, input logic [3:0] sz, input logic [31:0] base);
        logic [1:0] exp_c;
        string tag;
        @(negedge clk);
        desc_present = p; desc_user = u; desc_type = t; acc_kind = k;
        desc_limit = lim; desc_gran = g; desc_big = big;
        acc_offset = off; acc_bytes = sz; desc_base = base;
        exp_c = model_cause(p, u, t, k, lim, g, big, off, sz);
        @(negedge clk);
        vec++;
        if (!p) tag = "R2";
        else if (!u || k == 2'd3) tag = "R10";
        else if (exp_c == 2'd3) tag = t[3] ? "R7" : "R8";
        else if (!t[3] && t[2]) tag = "R6";
        else tag = "R5";
        expect_eq(tag, {30'd0, fault_cause}, {30'd0, exp_c});
        expect_eq("R3 fault flag", {31'd0, fault}, {31'd0, exp_c != 2'd0});
        expect_eq("R1 linear address", lin_addr, base + off);
    endtask

    function automatic logic [31:0] pick_offset(input int idx, input logic [31:0] eff);
        case (idx)
            0: return 32'd0;
            1: return eff - 32'd3;
            2: return eff - 32'd1;
            3: return eff;
            4: return eff + 32'd1;
            5: return 32'h0000FFFC;
            6: return 32'h0000FFFE;
            7: return 32'h0000FFFF;
            8: return 32'hFFFFFFFC;
            9: return 32'hFFFFFFFE;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [19:0] lims [4];
        logic [3:0]  sizes [3];
        lims[0] = 20'h00000; lims[1] = 20'h0000F; lims[2] = 20'h0FFFF; lims[3] = 20'hFFFFF;
        sizes[0] = 4'd1; sizes[1] = 4'd2; sizes[2] = 4'd4;

        // R3: reset state of all outputs.
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_eq("R3 reset address", lin_addr, 32'd0);
        expect_eq("R3 reset fault", {31'd0, fault}, 32'd0);
        expect_eq("R3 reset cause", {30'd0, fault_cause}, 32'd0);
        rst_n = 1'b1;

        // Main sweep: R4 via both granularities, R9 via type bit 0 both ways,
        // R11 where rights and bounds both fail.
        for (int g = 0; g < 2; g++)
            for (int li = 0; li < 4; li++)
                for (int big = 0; big < 2; big++)
                    for (int t = 0; t < 16; t++)
                        for (int k = 0; k < 3; k++)
                            for (int si = 0; si < 3; si++)
                                for (int oi = 0; oi < 11; oi++) begin
                                    logic [31:0] eff;
                                    eff = (g == 1) ? ({12'd0, lims[li]} << 12) | 32'hFFF
                                                   : {12'd0, lims[li]};
                                    run_vec(1'b1, 1'b1, 4'(t), 2'(k), lims[li], 1'(g), 1'(big),
                                            pick_offset(oi, eff), sizes[si],
                                            32'(vec) * 32'h9E3779B9);
                                end

        // R2, R10: absent segments, system descriptors and the unused kind code.
        for (int t = 0; t < 16; t++)
            for (int k = 0; k < 4; k++) begin
                run_vec(1'b0, 1'b1, 4'(t), 2'(k), 20'h0000F, 1'b0, 1'b0, 32'h20, 4'd1, 32'hFFFFFFF0);
                run_vec(1'b1, 1'b0, 4'(t), 2'(k), 20'hFFFFF, 1'b1, 1'b1, 32'h0, 4'd1, 32'h1000);
                run_vec(1'b1, 1'b1, 4'(t), 2'd3, 20'hFFFFF, 1'b1, 1'b1, 32'h4, 4'd2, 32'h0);
            end

        // Size boundary: 15-byte access ending exactly on and past the limit (R5).
        run_vec(1'b1, 1'b1, 4'b0010, 2'd0, 20'h00100, 1'b0, 1'b0, 32'h000F2, 4'd15, 32'h0);
        run_vec(1'b1, 1'b1, 4'b0010, 2'd0, 20'h00100, 1'b0, 1'b0, 32'h000F3, 4'd15, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule